// File: doc/BRIEF.md
# Streaming Pixel Format Packer

The packer takes one 32-bit pixel per cycle, laid out as alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0, and rewrites it into one of twelve memory layouts picked by a 4-bit format code. The code fixes both the bit depth (16, 24 or 32 bits per pixel) and the channel order. Converted pixels are laid into a little-endian byte stream and cut into 32-bit words, each carrying a 4-bit write strobe, ready for a memory write port.

Both sides use a valid/ready handshake. An end-of-line marker on the input closes the current line: a partly filled word is sent at once, with strobes only on the bytes it holds, and the last word of the line carries the output end-of-line flag. The alpha channel is either stored (and optionally inverted) or replaced by a constant that the invert bit chooses. A 4-bit byte-enable mask gates the store of each byte lane in every word. Codes with no layout are rejected: their pixels are consumed and dropped, and an error pulse is raised.

The configuration inputs (format, alpha controls, byte-enable mask) are expected to stay constant from the first pixel of a line until its last word has left the block.

Top module: `pix_packer`

## Requirements
- R1: Channel order follows the code, listed from most to least significant bits: 0 ABGR4444, 1 ARGB4444, 2 BGRA4444, 3 RGBA4444, 6 BGR565, 7 RGB565, 8 BGR888, 9 RGB888, 12 ABGR8888, 13 ARGB8888, 14 BGRA8888, 15 RGBA8888.
- R2: Narrowing an 8-bit channel to 4, 5 or 6 bits keeps its upper bits.
- R3: With alpha enable set, the pixel's alpha is stored in 4444 and 8888 layouts, bitwise inverted when the invert bit is set.
- R4: With alpha enable clear, the alpha field is all ones when the invert bit is 0 and all zeros when it is 1.
- R5: 16-bit layouts put two pixels in a word, the earlier pixel in bytes 1:0 and the later one in bytes 3:2.
- R6: 24-bit layouts use three bytes per pixel, packed back to back across word boundaries with byte 0 of the stream in bits 7:0 of a word.
- R7: 32-bit layouts give exactly one word per pixel.
- R8: An input pixel marked end-of-line closes the line: a partial word is emitted with strobes on its low filled bytes only and zeros in its unused bytes, the line's last word has the output end-of-line flag, and every other word has all strobes set before masking.
- R9: Output strobes are the filled-byte strobes ANDed with the byte-enable mask (bit n gates byte n); the data word is not altered by the mask.
- R10: Codes 4, 5, 10 and 11 are invalid: the pixel is accepted and dropped, no word results, its end-of-line marker is ignored, and the error output is high for exactly the cycle after acceptance.
- R11: A word presented while the output is not ready keeps its data, strobes and flag unchanged, and no input pixel is accepted meanwhile.
- R12: After reset, no word is presented, the error output is low and the input is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fmt_i | input | 4 | Output layout code |
| alpha_en_i | input | 1 | Store the pixel's alpha |
| alpha_inv_i | input | 1 | Invert stored alpha, or choose the fill constant |
| byte_en_i | input | 4 | Per-lane store enable mask |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_pix_i | input | 32 | Input pixel, A/R/G/B from high byte to low |
| in_eol_i | input | 1 | Pixel is the last one of its line |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream takes the word |
| out_data_o | output | 32 | Packed output word |
| out_strb_o | output | 4 | Byte write strobes |
| out_eol_o | output | 1 | Word is the last one of its line |
| err_o | output | 1 | Pulse: a pixel with an invalid code was dropped |

## Verification
A pixel accepted at a clock edge can complete a word that is presented from that same edge onward, so the bench's model turns each accepted pixel into expected words at the moment of acceptance and compares every transferred word, in order, on the falling edge in which it is handed over. A line whose end needs two words (24-bit layouts with five or six pending bytes) presents the second word one transfer later while the input is held off, which the ordered queue absorbs. The error pulse is due on the falling edge one cycle after the dropped pixel's accepting edge and is compared on every cycle, and the hold rule under back-pressure is checked by comparing each stalled word with its value one cycle earlier.

// File: rtl/pix_pkg.sv
package pix_pkg;
  localparam int unsigned PIX_W   = 32;
  localparam int unsigned WORD_B  = 4;
  localparam int unsigned WORD_W  = 8 * WORD_B;
  localparam int unsigned ACC_B   = WORD_B - 1;
  localparam int unsigned ACC_W   = 8 * ACC_B;
  localparam int unsigned WIDE_W  = ACC_W + WORD_W;
  localparam int unsigned CNT_W   = $clog2(WORD_B);
  localparam int unsigned NB_W    = $clog2(2 * WORD_B);

  typedef enum logic [1:0] {DEP_16, DEP_24, DEP_32, DEP_BAD} depth_e;

  function automatic depth_e depth_of(input logic [3:0] code);
    depth_e d;
    unique case (code[3:2])
      2'b00:   d = DEP_16;
      2'b01:   d = code[1] ? DEP_16 : DEP_BAD;
      2'b10:   d = code[1] ? DEP_BAD : DEP_24;
      default: d = DEP_32;
    endcase
    return d;
  endfunction

  function automatic logic [WORD_B-1:0] low_mask(input logic [NB_W-1:0] n);
    logic [WORD_B-1:0] m;
    for (int i = 0; i < WORD_B; i++) m[i] = (NB_W'(i) < n);
    return m;
  endfunction
endpackage

// File: rtl/pix_fmt_conv.sv
module pix_fmt_conv
  import pix_pkg::*;
(
  input  logic [3:0]       code_i,
  input  logic             alpha_en_i,
  input  logic             alpha_inv_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [WORD_W-1:0] val_o,
  output logic [NB_W-1:0]  nbytes_o,
  output logic             bad_o
);
  logic [7:0] a8, r8, g8, b8, hi8, lo8;
  depth_e     dep;

  always_comb begin
    r8  = pix_i[23:16];
    g8  = pix_i[15:8];
    b8  = pix_i[7:0];
    a8  = alpha_en_i ? (pix_i[31:24] ^ {8{alpha_inv_i}}) : {8{~alpha_inv_i}};
    hi8 = code_i[0] ? r8 : b8;
    lo8 = code_i[0] ? b8 : r8;
    dep = depth_of(code_i);
    val_o    = '0;
    nbytes_o = '0;
    bad_o    = 1'b0;
    unique case (dep)
      DEP_16: begin
        nbytes_o = NB_W'(2);
        if (code_i[2])
          val_o = {16'h0, hi8[7:3], g8[7:2], lo8[7:3]};
        else if (code_i[1])
          val_o = {16'h0, hi8[7:4], g8[7:4], lo8[7:4], a8[7:4]};
        else
          val_o = {16'h0, a8[7:4], hi8[7:4], g8[7:4], lo8[7:4]};
      end
      DEP_24: begin
        nbytes_o = NB_W'(3);
        val_o    = {8'h0, hi8, g8, lo8};
      end
      DEP_32: begin
        nbytes_o = NB_W'(4);
        val_o    = code_i[1] ? {hi8, g8, lo8, a8} : {a8, hi8, g8, lo8};
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pix_byte_accum.sv
module pix_byte_accum
  import pix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_bad_i,
  input  logic [WORD_W-1:0] in_val_i,
  input  logic [NB_W-1:0]   in_nb_i,
  input  logic              in_eol_i,
  input  logic [WORD_B-1:0] byte_en_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic [WORD_B-1:0] out_strb_o,
  output logic              out_eol_o,
  output logic              err_o
);
  logic [ACC_W-1:0]  acc_q, acc_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              flush_q, flush_n;
  logic              ov_q, ov_n;
  logic [WORD_W-1:0] od_q, od_n;
  logic [WORD_B-1:0] os_q, os_n;
  logic              oe_q, oe_n;
  logic              err_q, err_n;
  logic              ocan, fire, ld_out, ld_acc;
  logic [NB_W-1:0]   sum;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    ocan   = !ov_q || out_ready_i;
    in_ready_o = ocan && !flush_q;
    fire   = in_valid_i && in_ready_o;
    sum    = NB_W'(cnt_q) + in_nb_i;
    wide   = WIDE_W'(acc_q) | (WIDE_W'(in_val_i) << {cnt_q, 3'b000});
    ov_n   = ov_q && !out_ready_i;
    od_n   = od_q;
    os_n   = os_q;
    oe_n   = oe_q;
    acc_n  = acc_q;
    cnt_n  = cnt_q;
    flush_n = flush_q;
    err_n  = 1'b0;
    ld_out = 1'b0;
    ld_acc = 1'b0;
    if (flush_q && ocan) begin
      ld_out = 1'b1; ld_acc = 1'b1;
      od_n = WORD_W'(acc_q);
      os_n = low_mask(NB_W'(cnt_q)) & byte_en_i;
      oe_n = 1'b1;
      acc_n = '0; cnt_n = '0; flush_n = 1'b0;
    end else if (fire && in_bad_i) begin
      err_n = 1'b1;
    end else if (fire) begin
      ld_acc = 1'b1;
      if (sum >= NB_W'(WORD_B)) begin
        ld_out  = 1'b1;
        od_n    = wide[WORD_W-1:0];
        os_n    = byte_en_i;
        oe_n    = in_eol_i && (sum == NB_W'(WORD_B));
        acc_n   = wide[WIDE_W-1:WORD_W];
        cnt_n   = CNT_W'(sum - NB_W'(WORD_B));
        flush_n = in_eol_i && (sum > NB_W'(WORD_B));
      end else if (in_eol_i) begin
        ld_out = 1'b1;
        od_n   = wide[WORD_W-1:0];
        os_n   = low_mask(sum) & byte_en_i;
        oe_n   = 1'b1;
        acc_n  = '0; cnt_n = '0;
      end else begin
        acc_n = wide[ACC_W-1:0];
        cnt_n = CNT_W'(sum);
      end
    end
    if (ld_out) ov_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0; err_q <= 1'b0; flush_q <= 1'b0;
      cnt_q <= '0; acc_q <= '0;
      od_q <= '0; os_q <= '0; oe_q <= 1'b0;
    end else begin
      ov_q  <= ov_n;
      err_q <= err_n;
      if (ld_acc || (flush_q && ocan)) begin
        acc_q <= acc_n; cnt_q <= cnt_n; flush_q <= flush_n;
      end
      if (ld_out) begin
        od_q <= od_n; os_q <= os_n; oe_q <= oe_n;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign out_data_o  = od_q;
  assign out_strb_o  = os_q;
  assign out_eol_o   = oe_q;
  assign err_o       = err_q;
endmodule

// File: rtl/pix_packer.sv
module pix_packer
  import pix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fmt_i,
  input  logic              alpha_en_i,
  input  logic              alpha_inv_i,
  input  logic [WORD_B-1:0] byte_en_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PIX_W-1:0]  in_pix_i,
  input  logic              in_eol_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic [WORD_B-1:0] out_strb_o,
  output logic              out_eol_o,
  output logic              err_o
);
  logic [WORD_W-1:0] cv_val;
  logic [NB_W-1:0]   cv_nb;
  logic              cv_bad;

  pix_fmt_conv u_conv (
    .code_i      (fmt_i),
    .alpha_en_i  (alpha_en_i),
    .alpha_inv_i (alpha_inv_i),
    .pix_i       (in_pix_i),
    .val_o       (cv_val),
    .nbytes_o    (cv_nb),
    .bad_o       (cv_bad)
  );

  pix_byte_accum u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_bad_i    (cv_bad),
    .in_val_i    (cv_val),
    .in_nb_i     (cv_nb),
    .in_eol_i    (in_eol_i),
    .byte_en_i   (byte_en_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_strb_o  (out_strb_o),
    .out_eol_o   (out_eol_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/pix_packer_chk.sv
module pix_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  fmt_i,
  input logic [3:0]  byte_en_i,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_data_o,
  input logic [3:0]  out_strb_o,
  input logic        out_eol_o,
  input logic        err_o
);
  logic bad_code;
  assign bad_code = (fmt_i == 4'd4) || (fmt_i == 4'd5) || (fmt_i == 4'd10) || (fmt_i == 4'd11);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_strb_o) && $stable(out_eol_o)); // R11
  AST_NO_ACCEPT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R11
  AST_STRB_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_strb_o & ~byte_en_i) == 4'b0000); // R9
  AST_MIDLINE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_eol_o |-> out_strb_o == byte_en_i); // R8
  AST_ERR_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i && in_ready_o && bad_code |=> err_o); // R10
  AST_ERR_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(in_valid_i && in_ready_o)); // R10
endmodule

bind pix_packer pix_packer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fmt_i       (fmt_i),
  .byte_en_i   (byte_en_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_strb_o  (out_strb_o),
  .out_eol_o   (out_eol_o),
  .err_o       (err_o)
);

// File: tb/pix_packer_tb_top.sv
module pix_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt = 4'd13;
  logic        aen = 1'b1;
  logic        ainv = 1'b0;
  logic [3:0]  ben = 4'hF;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pix = '0;
  logic        in_eol = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0]  out_strb;
  logic        out_eol;
  logic        err;

  int checks = 0;
  int fails = 0;
  string cur_req = "R12";
  int bp_mode = 0;
  int cyc = 0;
  int pix_seq = 0;
  bit running = 1'b0;

  logic [31:0] exp_d[$];
  logic [3:0]  exp_s[$];
  logic        exp_e[$];
  logic [7:0]  bq[$];
  bit          err_exp = 1'b0;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_d;
  logic [3:0]  prev_s;
  logic        prev_e;

  always #5 clk = ~clk;

  pix_packer dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .alpha_en_i(aen), .alpha_inv_i(ainv),
    .byte_en_i(ben), .in_valid_i(in_valid), .in_ready_o(in_ready), .in_pix_i(in_pix),
    .in_eol_i(in_eol), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_strb_o(out_strb), .out_eol_o(out_eol), .err_o(err)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, expv);
    end
  endtask

  // behavioural layout model; returns byte count, 0 for a rejected code
  function automatic int ref_conv(input logic [3:0] c, input logic [31:0] p, output logic [31:0] v);
    logic [7:0] a, r, g, b;
    a = aen ? (p[31:24] ^ {8{ainv}}) : {8{~ainv}};
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    v = '0;
    case (c)
      4'd0:  begin v = {16'h0, a[7:4], b[7:4], g[7:4], r[7:4]}; return 2; end
      4'd1:  begin v = {16'h0, a[7:4], r[7:4], g[7:4], b[7:4]}; return 2; end
      4'd2:  begin v = {16'h0, b[7:4], g[7:4], r[7:4], a[7:4]}; return 2; end
      4'd3:  begin v = {16'h0, r[7:4], g[7:4], b[7:4], a[7:4]}; return 2; end
      4'd6:  begin v = {16'h0, b[7:3], g[7:2], r[7:3]}; return 2; end
      4'd7:  begin v = {16'h0, r[7:3], g[7:2], b[7:3]}; return 2; end
      4'd8:  begin v = {8'h0, b, g, r}; return 3; end
      4'd9:  begin v = {8'h0, r, g, b}; return 3; end
      4'd12: begin v = {a, b, g, r}; return 4; end
      4'd13: begin v = {a, r, g, b}; return 4; end
      4'd14: begin v = {b, g, r, a}; return 4; end
      4'd15: begin v = {r, g, b, a}; return 4; end
      default: return 0;
    endcase
  endfunction

  task automatic model_accept(input logic [31:0] p, input logic eol);
    logic [31:0] v;
    int nb;
    nb = ref_conv(fmt, p, v);
    if (nb == 0) return;
    for (int i = 0; i < nb; i++) bq.push_back(v[8*i +: 8]);
    while (bq.size() >= 4) begin
      logic [31:0] w;
      for (int i = 0; i < 4; i++) w[8*i +: 8] = bq.pop_front();
      exp_d.push_back(w); exp_s.push_back(ben);
      exp_e.push_back(eol && (bq.size() == 0));
    end
    if (eol && bq.size() > 0) begin
      logic [31:0] w;
      logic [3:0]  m;
      w = '0; m = '0;
      for (int i = 0; bq.size() > 0; i++) begin
        w[8*i +: 8] = bq.pop_front();
        m[i] = 1'b1;
      end
      exp_d.push_back(w); exp_s.push_back(m & ben); exp_e.push_back(1'b1);
    end
  endtask

  // monitor, every falling edge
  always @(negedge clk) begin
    cyc++;
    if (running) begin
      if (prev_stall) begin
        check(out_valid && out_data == prev_d && out_strb == prev_s && out_eol == prev_e,
              "R11 stalled word changed", out_data, prev_d);
      end
      if (out_valid && !out_ready) check(!in_ready, "R11 input ready while blocked", 32'(in_ready), 0);
      prev_stall = out_valid && !out_ready;
      prev_d = out_data; prev_s = out_strb; prev_e = out_eol;
      check(err == err_exp, "R10 error pulse", 32'(err), 32'(err_exp));
      err_exp = in_valid && in_ready && (ref_conv(fmt, in_pix, prev_d) == 0);
      prev_d = out_data;
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          check(1'b0, "unexpected word", out_data, 0);
        end else begin
          logic [31:0] ed; logic [3:0] es; logic ee;
          ed = exp_d.pop_front(); es = exp_s.pop_front(); ee = exp_e.pop_front();
          check(out_data == ed, "data", out_data, ed);
          check(out_strb == es, "R9/R8 strobe", 32'(out_strb), 32'(es));
          check(out_eol == ee, "R8 eol flag", 32'(out_eol), 32'(ee));
        end
      end
      if (in_valid && in_ready) model_accept(in_pix, in_eol);
    end
  end

  // back-pressure source
  always @(posedge clk) begin
    #2;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = (cyc % 5) < 2;
    endcase
  end

  task automatic send(input logic eol);
    pix_seq++;
    in_valid = 1'b1;
    in_pix = 32'h9E3779B9 * pix_seq + 32'h1234567 * (pix_seq % 7);
    in_eol = eol;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0; in_eol = 1'b0;
  endtask

  task automatic line(input int n);
    for (int i = 0; i < n; i++) send(i == n - 1);
  endtask

  task automatic drain();
    int guard = 0;
    do begin @(negedge clk); guard++; end while ((exp_d.size() != 0 || out_valid) && guard < 500);
    repeat (2) @(negedge clk);
    check(exp_d.size() == 0, "words missing", 32'(exp_d.size()), 0);
    @(posedge clk); #2;
  endtask

  task automatic cfg(input logic [3:0] f, input logic ae, input logic ai, input logic [3:0] be);
    fmt = f; aen = ae; ainv = ai; ben = be;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!out_valid, "R12 out_valid after reset", 32'(out_valid), 0);
    check(!err, "R12 err after reset", 32'(err), 0);
    check(in_ready, "R12 in_ready after reset", 32'(in_ready), 1);
    running = 1'b1;
    @(posedge clk); #2;

    // R1 R7 R3: 8888 orders, stored alpha plain and inverted
    cur_req = "R1/R7/R3";
    for (int f = 12; f < 16; f++) begin
      cfg(4'(f), 1'b1, 1'b0, 4'hF); line(3); drain();
      cfg(4'(f), 1'b1, 1'b1, 4'hF); line(2); drain();
    end
    // R4 alpha fill constants
    cur_req = "R4";
    cfg(4'd15, 1'b0, 1'b0, 4'hF); line(2); drain();
    cfg(4'd12, 1'b0, 1'b1, 4'hF); line(2); drain();
    cfg(4'd1, 1'b0, 1'b1, 4'hF); line(2); drain();
    // R5 R2 R8: 4444 and 565, odd and even line lengths
    cur_req = "R5/R2/R8";
    for (int f = 0; f < 4; f++) begin
      cfg(4'(f), 1'b1, 1'b0, 4'hF); line(3); drain();
      cfg(4'(f), 1'b1, 1'b1, 4'hF); line(4); drain();
    end
    cfg(4'd6, 1'b1, 1'b0, 4'hF); line(5); drain();
    cfg(4'd7, 1'b1, 1'b0, 4'hF); line(4); drain();
    // R6 R8: 888 across word edges, every remainder
    cur_req = "R6/R8";
    for (int n = 1; n < 7; n++) begin
      cfg(4'd8, 1'b1, 1'b0, 4'hF); line(n); drain();
      cfg(4'd9, 1'b1, 1'b0, 4'hF); line(n); drain();
    end
    // R9 byte-enable mask
    cur_req = "R9";
    cfg(4'd13, 1'b1, 1'b0, 4'b0101); line(3); drain();
    cfg(4'd9, 1'b1, 1'b0, 4'b1010); line(5); drain();
    cfg(4'd7, 1'b1, 1'b0, 4'b0011); line(3); drain();
    // R10 rejected codes, with and without end-of-line
    cur_req = "R10";
    cfg(4'd4, 1'b1, 1'b0, 4'hF); line(2); drain();
    cfg(4'd5, 1'b1, 1'b0, 4'hF); line(1); drain();
    cfg(4'd10, 1'b1, 1'b0, 4'hF); line(3); drain();
    cfg(4'd11, 1'b1, 1'b0, 4'hF); line(2); drain();
    check(!out_valid, "R10 no word from rejected code", 32'(out_valid), 0);
    cfg(4'd13, 1'b1, 1'b0, 4'hF); line(2); drain();
    // R11 back-pressure
    cur_req = "R11";
    bp_mode = 1;
    cfg(4'd8, 1'b1, 1'b0, 4'hF); line(7); drain();
    cfg(4'd0, 1'b1, 1'b0, 4'hF); line(5); drain();
    bp_mode = 2;
    cfg(4'd14, 1'b1, 1'b1, 4'hF); line(6); drain();
    cfg(4'd9, 1'b0, 1'b0, 4'hF); for (int k = 0; k < 3; k++) line(3); drain();
    bp_mode = 0;
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule